// File: doc/BRIEF.md
# One-Hot State Legality Checker

This block watches the state register of a one-hot finite state machine and raises a single error flag whenever that register does not hold exactly one set bit. Both the all-zero vector and any pattern with two or more bits set count as illegal. The flag is meant to feed a recovery or alarm path elsewhere in the chip. Recovery itself is not part of this block.

The check is built as a shallow reduction tree instead of a population count. Each leaf looks at a small group of state bits and produces two signals. One is true when the group has no bit set, and the other is true when the group has exactly one bit set. Each tree node applies the same reduction to the signal pairs of its children. The error flag is the inverse of the root's "exactly one" signal.

The flag is available straight from the logic with no latency. A second output carries either a registered copy of the flag or, when registering is disabled by parameter, the same value as the combinational flag.

Top module: `onehot_guard`

## Requirements
- R1: With all state bits at 0, `illegal_now` is 1.
- R2: For each of the `STATE_W` codes with exactly one bit set, `illegal_now` is 0.
- R3: For every input pattern with two or more bits set, `illegal_now` is 1.
- R4: `illegal_now` settles within the same clock cycle that `state_vec` changes, with no register between input and output.
- R5: With `REGISTER_OUT`=1 and `rst_n` high, `illegal_q` equals the `illegal_now` value sampled at the previous rising edge of `clk`.
- R6: With `REGISTER_OUT`=1, a rising edge of `clk` while `rst_n` is 0 sets `illegal_q` to 0, whatever the value of `state_vec`.
- R7: With `REGISTER_OUT`=0, `illegal_q` equals `illegal_now` in every cycle.
- R8: `STATE_W` must be a whole power of `GROUP_W`, and `GROUP_W` must be at least 2. Any other setting stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous reset, active low, clears `illegal_q` |
| state_vec | input | STATE_W | State register of the monitored machine |
| illegal_now | output | 1 | 1 when `state_vec` is not exactly one-hot, combinational |
| illegal_q | output | 1 | Registered copy of `illegal_now`, or a pass-through when `REGISTER_OUT`=0 |

## Verification
The bench applies all 65536 values of a 16-bit state vector and compares the flag with a bit count done in the bench. This covers several failure modes:
- A tree that treats "none set" as legal would miss the all-zero vector.
- A parent that accepts two children each reporting "exactly one" would pass every pattern whose two set bits fall in different groups.
- A leaf that ignores a bit position would pass the patterns with two set bits in the same group.

The registered output is checked one cycle behind the combinational flag, and it is checked to clear during reset while an illegal pattern is present. A second instance without the register is checked to follow the flag in the same cycle.

// File: rtl/onehot_guard_pkg.sv
package onehot_guard_pkg;

   typedef struct packed {
      logic none;
      logic one;
   } ohg_pair_t;

   // number of tree levels needed to reduce w bits in groups of g
   function automatic int ohg_levels(input int w, input int g);
      int n;
      int l;
      n = w;
      l = 0;
      while (n > 1) begin
         n = n / g;
         l = l + 1;
      end
      return l;
   endfunction

   // true when w is g raised to a whole power of at least one
   function automatic bit ohg_is_power(input int w, input int g);
      int n;
      if (g < 2 || w < g) return 1'b0;
      n = w;
      while (n > 1) begin
         if ((n % g) != 0) return 1'b0;
         n = n / g;
      end
      return 1'b1;
   endfunction

   // node count at tree level k (level 0 = leaves)
   function automatic int ohg_nodes(input int w, input int g, input int k);
      int n;
      n = w;
      for (int i = 0; i <= k; i++) n = n / g;
      return n;
   endfunction

   // first index of level k in the flat node array
   function automatic int ohg_offset(input int w, input int g, input int k);
      int s;
      s = 0;
      for (int i = 0; i < k; i++) s = s + ohg_nodes(w, g, i);
      return s;
   endfunction

   function automatic int ohg_total(input int w, input int g);
      return ohg_offset(w, g, ohg_levels(w, g));
   endfunction

endpackage

// File: rtl/onehot_leaf.sv
module onehot_leaf
   import onehot_guard_pkg::*;
#(
   parameter int GROUP_W = 4
) (
   input  logic [GROUP_W-1:0] bits,
   output ohg_pair_t          pair_o
);

   always_comb begin
      logic acc_none;
      logic acc_one;
      acc_none = 1'b1;
      acc_one  = 1'b0;
      for (int i = 0; i < GROUP_W; i++) begin
         acc_one  = (acc_one & ~bits[i]) | (acc_none & bits[i]);
         acc_none = acc_none & ~bits[i];
      end
      pair_o.none = acc_none;
      pair_o.one  = acc_one;
   end

endmodule

// File: rtl/onehot_merge.sv
module onehot_merge
   import onehot_guard_pkg::*;
#(
   parameter int GROUP_W = 4
) (
   input  ohg_pair_t [GROUP_W-1:0] kids,
   output ohg_pair_t               pair_o
);

   always_comb begin
      logic acc_none;
      logic acc_one;
      acc_none = 1'b1;
      acc_one  = 1'b0;
      for (int i = 0; i < GROUP_W; i++) begin
         acc_one  = (acc_one & kids[i].none) | (acc_none & kids[i].one);
         acc_none = acc_none & kids[i].none;
      end
      pair_o.none = acc_none;
      pair_o.one  = acc_one;
   end

endmodule

// File: rtl/onehot_guard.sv
module onehot_guard
   import onehot_guard_pkg::*;
#(
   parameter int STATE_W      = 16,
   parameter int GROUP_W      = 4,
   parameter bit REGISTER_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STATE_W-1:0] state_vec,
   output logic               illegal_now,
   output logic               illegal_q
);

   localparam int LEVELS = ohg_levels(STATE_W, GROUP_W);
   localparam int LEAVES = STATE_W / GROUP_W;
   localparam int TOTAL  = ohg_total(STATE_W, GROUP_W);

   // R8: elaboration-time parameter checks
   if (GROUP_W < 2) begin : g_bad_group
      $error("onehot_guard: GROUP_W must be at least 2");
   end
   if (!ohg_is_power(STATE_W, GROUP_W)) begin : g_bad_width
      $error("onehot_guard: STATE_W must be a whole power of GROUP_W");
   end

   ohg_pair_t node [TOTAL];

   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      onehot_leaf #(.GROUP_W(GROUP_W)) u_leaf (
         .bits   (state_vec[i*GROUP_W +: GROUP_W]),
         .pair_o (node[i])
      );
   end

   for (genvar k = 1; k < LEVELS; k++) begin : g_level
      localparam int CNT  = ohg_nodes(STATE_W, GROUP_W, k);
      localparam int OFF  = ohg_offset(STATE_W, GROUP_W, k);
      localparam int COFF = ohg_offset(STATE_W, GROUP_W, k - 1);
      for (genvar n = 0; n < CNT; n++) begin : g_node
         ohg_pair_t [GROUP_W-1:0] kids_w;
         for (genvar c = 0; c < GROUP_W; c++) begin : g_kid
            assign kids_w[c] = node[COFF + n*GROUP_W + c];
         end
         onehot_merge #(.GROUP_W(GROUP_W)) u_merge (
            .kids   (kids_w),
            .pair_o (node[OFF + n])
         );
      end
   end

   ohg_pair_t root;
   assign root        = node[TOTAL-1];
   assign illegal_now = ~root.one;

   if (REGISTER_OUT) begin : g_reg
      logic flag_q;
      always_ff @(posedge clk) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= illegal_now;
      end
      assign illegal_q = flag_q;

      assert_reg_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
         illegal_now |=> illegal_q);
      assert_reg_follows_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !illegal_now |=> !illegal_q);
   end else begin : g_pass
      assign illegal_q = illegal_now;

      assert_pass_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
         illegal_q == illegal_now);
   end

   assert_zero_flagged_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_vec == '0) |-> illegal_now);
   assert_single_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(state_vec) == 1) |-> !illegal_now);
   assert_multi_flagged_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(state_vec) > 1) |-> illegal_now);
   assert_root_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(root.none && root.one));

endmodule

// File: tb/onehot_guard_tb.sv
module onehot_guard_tb_top;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] state_vec = '0;
   logic         now_r, q_r, now_c, q_c;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   onehot_guard #(.STATE_W(W), .GROUP_W(4), .REGISTER_OUT(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .state_vec(state_vec),
      .illegal_now(now_r), .illegal_q(q_r));

   onehot_guard #(.STATE_W(W), .GROUP_W(4), .REGISTER_OUT(1'b0)) dut_comb_i (
      .clk(clk), .rst_n(rst_n), .state_vec(state_vec),
      .illegal_now(now_c), .illegal_q(q_c));

   function automatic logic expect_flag(input logic [W-1:0] v);
      int n;
      n = 0;
      for (int i = 0; i < W; i++) n += int'(v[i]);
      return (n != 1);
   endfunction

   function automatic string req_of(input logic [W-1:0] v);
      int n;
      n = 0;
      for (int i = 0; i < W; i++) n += int'(v[i]);
      if (n == 0) return "R1";
      if (n == 1) return "R2";
      return "R3";
   endfunction

   task automatic check(input logic act, input logic exp, input string req,
                        input logic [W-1:0] v);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s vec=%h actual=%b expected=%b", req, v, act, exp);
      end
   endtask

   initial begin
      logic prev_exp;
      logic [W-1:0] prev_vec;
      bit have_prev;
      // reset state: R6 with an illegal (all-zero) input present, R1 on the flag
      repeat (3) @(negedge clk);
      check(q_r, 1'b0, "R6", state_vec);
      check(now_r, 1'b1, "R1", state_vec);
      rst_n = 1'b1;
      have_prev = 1'b0;
      prev_exp  = 1'b0;
      prev_vec  = '0;
      for (int p = 0; p < (1 << W); p++) begin
         @(negedge clk);
         if (have_prev) check(q_r, prev_exp, "R5", prev_vec);
         state_vec = W'(p);
         #1;
         // R4: flag valid in the same cycle, R1/R2/R3 by bit count
         check(now_r, expect_flag(state_vec), {req_of(state_vec), "/R4"}, state_vec);
         check(now_c, expect_flag(state_vec), req_of(state_vec), state_vec);
         check(q_c, expect_flag(state_vec), "R7", state_vec);
         prev_exp  = expect_flag(state_vec);
         prev_vec  = state_vec;
         have_prev = 1'b1;
      end
      @(negedge clk);
      check(q_r, prev_exp, "R5", prev_vec);
      // mid-run reset with a multi-hot input: R6
      state_vec = 16'h0003;
      @(negedge clk);
      check(q_r, 1'b1, "R5", state_vec);
      rst_n = 1'b0;
      @(negedge clk);
      check(q_r, 1'b0, "R6", state_vec);
      check(now_r, 1'b1, "R3", state_vec);
      rst_n = 1'b1;
      @(negedge clk);
      check(q_r, 1'b1, "R5", state_vec);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 190000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule